// File: doc/BRIEF.md
# Eight-Lane Vector ALU Engine

This block is one vector execution slot of a wide-issue machine. Each issued operation names a destination base address and two source base addresses in a scratch register file. A vector operand at base `d` is the eight consecutive scratch entries `d` through `d+7`. The engine sends the two source bases out as read requests, receives the eight-word operands back in the same cycle, and computes one of twelve element-wise operations across all eight lanes. It also has a broadcast operation that copies one scalar into every lane.

The result is captured in a register and presented one cycle later as a write bundle. The bundle holds a single enable for all eight lanes, the destination base address and the eight result words. The scratch file commits the bundle at the next clock edge. Operand reads therefore always see the contents from before any write produced by the same operation, because every effect lands at the end of the cycle.

All words are 32-bit unsigned. Fetch, slot arbitration and memory access belong to other blocks.

Top module: `vlane_engine`

## Requirements
- R1: `rd_a_base`/`rd_b_base` equal `src_a_base`/`src_b_base` in the same cycle. Lane i of every data bus is bits [32i+31:32i] and maps to scratch entry base+i. `wr_base` carries the `dst_base` of the issue that produced the bundle.
- R2: Codes 0 (add), 1 (subtract) and 2 (multiply) give the per-lane result modulo 2^32.
- R3: Codes 3 (divide) and 4 (modulo) are unsigned per lane. A lane whose divisor is 0 yields 0, and the other lanes are not affected.
- R4: Codes 5 (AND), 6 (OR) and 7 (XOR) are bitwise per lane.
- R5: Codes 8 (left shift) and 9 (logical right shift) shift lane A by the low 5 bits of lane B.
- R6: Codes 10 (less-than) and 11 (equal) compare unsigned and write exactly 1 when true and 0 when false in each lane.
- R7: Code 12 (broadcast) writes lane 0 of operand A into all eight lanes. Operand B has no effect.
- R8: `wr_en` goes high for exactly one cycle, in the cycle after an issue with a legal code, and the bundle holds that issue's result. Without an issue, `wr_en` is low.
- R9: Codes 13, 14 and 15 are illegal. They produce no write (`wr_en` stays low).
- R10: With `rst_n` low at a clock edge (synchronous reset), `wr_en`, `wr_base` and `wr_data` clear to 0, even if an issue is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An operation is issued this cycle |
| issue_op | input | 4 | Operation code (0 to 12 legal) |
| dst_base | input | 10 | Destination base scratch address |
| src_a_base | input | 10 | Operand A base scratch address |
| src_b_base | input | 10 | Operand B base scratch address |
| rd_a_base | output | 10 | Read request base for operand A |
| rd_b_base | output | 10 | Read request base for operand B |
| rd_a_data | input | 256 | Eight words of operand A from scratch |
| rd_b_data | input | 256 | Eight words of operand B from scratch |
| wr_en | output | 1 | Write enable covering all eight lanes |
| wr_base | output | 10 | Destination base of the write |
| wr_data | output | 256 | Eight result words |

## Verification
The bench mixes zero and non-zero divisors across the lanes of one divide and one modulo. A design that traps, or that forces every lane to zero, would show wrong values in the non-zero lanes. Shift amounts above 31 check the 5-bit truncation, since a full-width shift would return 0 instead of a shifted value. Comparisons use words with the top bit set, which a signed compare would order the wrong way. Broadcast runs with junk on operand B, and illegal codes, back-to-back issues and a reset that arrives together with an issue check that `wr_en` never lasts too long and never fires spuriously.

// File: rtl/vlane_pkg.sv
// Package: shared sizes and operation codes for the vector lane engine.
// Assumes: unsigned words; code values are fixed by the issue format.
package vlane_pkg;
    localparam int unsigned VLANES  = 8;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ADDR_W  = 10;
    localparam int unsigned OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_MUL   = 4'd2,
        OP_DIV   = 4'd3,
        OP_MOD   = 4'd4,
        OP_AND   = 4'd5,
        OP_OR    = 4'd6,
        OP_XOR   = 4'd7,
        OP_SHL   = 4'd8,
        OP_SHR   = 4'd9,
        OP_LT    = 4'd10,
        OP_EQ    = 4'd11,
        OP_BCAST = 4'd12
    } vop_e;

    localparam logic [OP_W-1:0] OP_LAST_LEGAL = 4'd12;
endpackage

// File: rtl/vlane_decode.sv
// Module: vlane_decode
// Turns the raw operation code into a typed operation and a legality flag.
// Assumes: codes above OP_LAST_LEGAL are illegal and must not write.
module vlane_decode
    import vlane_pkg::*;
(
    input  logic [OP_W-1:0] op_raw,
    output vop_e            op,
    output logic            legal
);
    // Classify the code and cast it to the operation type.
    always_comb begin
        legal = (op_raw <= OP_LAST_LEGAL);
        op    = vop_e'(op_raw);
    end
endmodule

// File: rtl/vlane_alu.sv
// Module: vlane_alu
// One lane of the vector datapath: combinational element operation.
// Assumes: unsigned operands; divide or modulo by zero yields zero;
// shifts use only the low log2(DW) bits of operand b.
module vlane_alu
    import vlane_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  vop_e          op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] bcast_val,
    output logic [DW-1:0] y
);
    localparam int unsigned SHW = $clog2(DW);

    logic          b_zero;
    logic [SHW-1:0] shamt;

    // Derive the divisor-zero flag and the truncated shift amount.
    always_comb begin
        b_zero = (b == '0);
        shamt  = b[SHW-1:0];
    end

    // Select the lane result for the issued operation.
    always_comb begin
        case (op)
            OP_ADD:   y = a + b;
            OP_SUB:   y = a - b;
            OP_MUL:   y = a * b;
            OP_DIV:   y = b_zero ? '0 : a / b;
            OP_MOD:   y = b_zero ? '0 : a % b;
            OP_AND:   y = a & b;
            OP_OR:    y = a | b;
            OP_XOR:   y = a ^ b;
            OP_SHL:   y = a << shamt;
            OP_SHR:   y = a >> shamt;
            OP_LT:    y = {{(DW-1){1'b0}}, (a < b)};
            OP_EQ:    y = {{(DW-1){1'b0}}, (a == b)};
            OP_BCAST: y = bcast_val;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/vlane_engine.sv
// Module: vlane_engine (top)
// Vector execution slot: issues two base-address read requests, computes
// an element-wise operation over LANES words and registers a write
// bundle (one enable, base address, LANES words) for the next cycle.
// Assumes: read data returns combinationally in the issue cycle and the
// scratch file commits the bundle at the following edge.
module vlane_engine
    import vlane_pkg::*;
#(
    parameter int unsigned LANES = VLANES,
    parameter int unsigned DW    = WORD_W,
    parameter int unsigned AW    = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [OP_W-1:0]    issue_op,
    input  logic [AW-1:0]      dst_base,
    input  logic [AW-1:0]      src_a_base,
    input  logic [AW-1:0]      src_b_base,
    output logic [AW-1:0]      rd_a_base,
    output logic [AW-1:0]      rd_b_base,
    input  logic [LANES*DW-1:0] rd_a_data,
    input  logic [LANES*DW-1:0] rd_b_data,
    output logic               wr_en,
    output logic [AW-1:0]      wr_base,
    output logic [LANES*DW-1:0] wr_data
);
    localparam int unsigned BUS_W = LANES * DW;

    vop_e             dec_op;
    logic             dec_legal;
    logic             fire;
    logic [BUS_W-1:0] lane_res;

    vlane_decode u_dec (
        .op_raw (issue_op),
        .op     (dec_op),
        .legal  (dec_legal)
    );

    // Pass source bases straight out as scratch read requests.
    always_comb begin
        rd_a_base = src_a_base;
        rd_b_base = src_b_base;
        fire      = issue_valid && dec_legal;
    end

    // Replicate one datapath lane per vector element.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vlane_alu #(.DW(DW)) u_alu (
            .op        (dec_op),
            .a         (rd_a_data[g*DW +: DW]),
            .b         (rd_b_data[g*DW +: DW]),
            .bcast_val (rd_a_data[DW-1:0]),
            .y         (lane_res[g*DW +: DW])
        );

        // R3: a zero divisor in this lane gives zero in this lane.
        a_r3_divzero_lane: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_valid && (issue_op == OP_DIV || issue_op == OP_MOD)
             && rd_b_data[g*DW +: DW] == '0)
            |=> (wr_data[g*DW +: DW] == '0));

        // R6: compare results are only ever 0 or 1.
        a_r6_cmp_bool: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_valid && (issue_op == OP_LT || issue_op == OP_EQ))
            |=> (wr_data[g*DW +: DW] <= 1));

        // R7: broadcast fills the lane with lane 0 of operand A.
        a_r7_bcast_fill: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_valid && issue_op == OP_BCAST)
            |=> (wr_data[g*DW +: DW] == $past(rd_a_data[DW-1:0])));
    end

    // Register the write bundle; synchronous active-low reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_base <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= fire;
            if (fire) begin
                wr_base <= dst_base;
                wr_data <= lane_res;
            end
        end
    end

    // R8: a legal issue writes in the next cycle.
    a_r8_issue_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_op <= OP_LAST_LEGAL) |=> wr_en);

    // R9: no issue or an illegal code leaves the enable low.
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && issue_op <= OP_LAST_LEGAL) |=> !wr_en);

    // R1: the bundle carries the destination base of its issue.
    a_r1_dst_base: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_op <= OP_LAST_LEGAL) |=> (wr_base == $past(dst_base)));

    // R10: reset leaves the enable cleared.
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !wr_en);
endmodule

// File: tb/sim_vlane_engine.sv
`timescale 1ns/1ps
module sim_vlane_engine;
    localparam int L  = 8;
    localparam int DW = 32;
    localparam int AW = 10;
    localparam int BW = L * DW;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] sa;
        logic [31:0] b;
        logic [31:0] sb;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{4'd0,  32'hFFFF_FFF0, 32'd3,  32'd20,        32'd1},
        '{4'd1,  32'd5,         32'd1,  32'd9,         32'd0},
        '{4'd2,  32'h0001_0001, 32'd7,  32'h0000_FFFF, 32'd3},
        '{4'd3,  32'd1000,      32'd37, 32'd7,         32'd2},
        '{4'd4,  32'hFFFF_FFFF, 32'd11, 32'd13,        32'd5},
        '{4'd5,  32'hF0F0_F0F0, 32'd1,  32'h0FF0_0FF0, 32'd0},
        '{4'd6,  32'h1200_0000, 32'd1,  32'h0000_0034, 32'd2},
        '{4'd7,  32'hAAAA_AAAA, 32'd0,  32'h5555_5555, 32'd1},
        '{4'd8,  32'h8000_0001, 32'd0,  32'd0,         32'd5},
        '{4'd9,  32'h8000_0000, 32'd0,  32'd30,        32'd1},
        '{4'd10, 32'h7FFF_FFFC, 32'd1,  32'h7FFF_FFFF, 32'd0},
        '{4'd10, 32'h8000_0000, 32'd0,  32'd1,         32'd0},
        '{4'd11, 32'd10,        32'd1,  32'd13,        32'd0},
        '{4'd12, 32'hDEAD_BEEF, 32'd5,  32'h1234_5678, 32'd9},
        '{4'd2,  32'hFFFF_FFFF, 32'd0,  32'hFFFF_FFFF, 32'd0}
    };

    logic           clk = 0;
    logic           rst_n;
    logic           issue_valid;
    logic [3:0]     issue_op;
    logic [AW-1:0]  dst_base, src_a_base, src_b_base;
    logic [AW-1:0]  rd_a_base, rd_b_base;
    logic [BW-1:0]  rd_a_data, rd_b_data;
    logic           wr_en;
    logic [AW-1:0]  wr_base;
    logic [BW-1:0]  wr_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vlane_engine u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .dst_base(dst_base), .src_a_base(src_a_base), .src_b_base(src_b_base),
        .rd_a_base(rd_a_base), .rd_b_base(rd_b_base),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_base(wr_base), .wr_data(wr_data)
    );

    function automatic logic [BW-1:0] ramp(logic [31:0] base, logic [31:0] step);
        logic [BW-1:0] v;
        for (int i = 0; i < L; i++) v[i*DW +: DW] = base + step * i;
        return v;
    endfunction

    // Reference per-lane result written from the requirement list.
    function automatic logic [31:0] ref_lane(logic [3:0] op, logic [31:0] x,
                                             logic [31:0] y, logic [31:0] s0);
        case (op)
            4'd0:  return x + y;
            4'd1:  return x - y;
            4'd2:  return 32'((64'(x) * 64'(y)) & 64'hFFFF_FFFF);
            4'd3:  return (y == 0) ? 32'd0 : x / y;
            4'd4:  return (y == 0) ? 32'd0 : x % y;
            4'd5:  return x & y;
            4'd6:  return x | y;
            4'd7:  return x ^ y;
            4'd8:  return x << (y % 32);
            4'd9:  return x >> (y % 32);
            4'd10: return (x < y) ? 32'd1 : 32'd0;
            4'd11: return (x == y) ? 32'd1 : 32'd0;
            4'd12: return s0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [BW-1:0] ref_vec(logic [3:0] op, logic [BW-1:0] va,
                                              logic [BW-1:0] vb);
        logic [BW-1:0] r;
        for (int i = 0; i < L; i++)
            r[i*DW +: DW] = ref_lane(op, va[i*DW +: DW], vb[i*DW +: DW], va[DW-1:0]);
        return r;
    endfunction

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2:  return "R2";
            4'd3, 4'd4:        return "R3";
            4'd5, 4'd6, 4'd7:  return "R4";
            4'd8, 4'd9:        return "R5";
            4'd10, 4'd11:      return "R6";
            4'd12:             return "R7";
            default:           return "R9";
        endcase
    endfunction

    task automatic chk(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one issue at a falling edge; outputs are sampled one cycle on.
    task automatic drive(logic v, logic [3:0] op, logic [AW-1:0] d,
                         logic [BW-1:0] va, logic [BW-1:0] vb);
        issue_valid = v;
        issue_op    = op;
        dst_base    = d;
        src_a_base  = d + 10'd16;
        src_b_base  = d + 10'd32;
        rd_a_data   = va;
        rd_b_data   = vb;
    endtask

    task automatic idle();
        drive(1'b0, 4'd0, '0, '0, '0);
    endtask

    initial begin
        #(8 * 5000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [BW-1:0] va, vb, e1;
        rst_n = 0;
        idle();
        repeat (3) @(negedge clk);
        // R10: state after reset
        chk("R10 reset wr_en", BW'(wr_en), '0);
        chk("R10 reset wr_base", BW'(wr_base), '0);
        chk("R10 reset wr_data", wr_data, '0);
        rst_n = 1;
        @(negedge clk);

        // Table walk over every legal code
        for (int k = 0; k < NV; k++) begin
            va = ramp(TBL[k].a, TBL[k].sa);
            vb = ramp(TBL[k].b, TBL[k].sb);
            drive(1'b1, TBL[k].op, AW'(k * 8), va, vb);
            #1;
            chk("R1 read bases", BW'({rd_a_base, rd_b_base}),
                BW'({AW'(k * 8 + 16), AW'(k * 8 + 32)}));
            @(negedge clk);
            idle();
            chk({tag_of(TBL[k].op), " R8 wr_en"}, BW'(wr_en), BW'(1));
            chk("R1 wr_base", BW'(wr_base), BW'(k * 8));
            chk({tag_of(TBL[k].op), " data"}, wr_data, ref_vec(TBL[k].op, va, vb));
            @(negedge clk);
            chk("R8 single-cycle enable", BW'(wr_en), '0);
        end

        // R1: lane order, lane 3 of an add is base+3 element
        va = ramp(32'd100, 32'd10);
        vb = ramp(32'd0, 32'd1);
        drive(1'b1, 4'd0, 10'd40, va, vb);
        @(negedge clk); idle();
        chk("R1 lane 3 position", BW'(wr_data[3*DW +: DW]), BW'(133));

        // R3: mixed zero and non-zero divisors in one vector
        va = ramp(32'd50, 32'd1);
        vb = '0;
        vb[1*DW +: DW] = 32'd7;
        vb[6*DW +: DW] = 32'd4;
        drive(1'b1, 4'd3, 10'd8, va, vb);
        @(negedge clk);
        e1 = '0; e1[1*DW +: DW] = 32'd7; e1[6*DW +: DW] = 32'd14;
        chk("R3 div by zero lanes", wr_data, e1);
        drive(1'b1, 4'd4, 10'd8, va, vb);
        @(negedge clk); idle();
        e1 = '0; e1[1*DW +: DW] = 32'd2; e1[6*DW +: DW] = 32'd0;
        chk("R3 mod by zero lanes", wr_data, e1);

        // R5: shift amount 33 uses low 5 bits (shift by 1)
        drive(1'b1, 4'd8, 10'd0, {L{32'h0000_0003}}, {L{32'd33}});
        @(negedge clk); idle();
        chk("R5 shift amount truncation", wr_data, {L{32'h0000_0006}});

        // R7: broadcast ignores operand B
        va = ramp(32'hCAFE_0000, 32'd1);
        drive(1'b1, 4'd12, 10'd64, va, {L{32'hFFFF_FFFF}});
        @(negedge clk); idle();
        chk("R7 broadcast ignores B", wr_data, {L{32'hCAFE_0000}});

        // R9: illegal codes produce no write, previous bundle untouched
        drive(1'b1, 4'd13, 10'd99, va, va);
        @(negedge clk);
        chk("R9 code 13 no write", BW'(wr_en), '0);
        drive(1'b1, 4'd15, 10'd99, va, va);
        @(negedge clk); idle();
        chk("R9 code 15 no write", BW'(wr_en), '0);

        // R8: back-to-back issues, each result in the following cycle
        drive(1'b1, 4'd0, 10'd1, {L{32'd1}}, {L{32'd2}});
        @(negedge clk);
        drive(1'b1, 4'd7, 10'd2, {L{32'd1}}, {L{32'd2}});
        chk("R8 back-to-back first", wr_data, {L{32'd3}});
        @(negedge clk); idle();
        chk("R8 back-to-back second", BW'({wr_en, wr_base}), BW'({1'b1, 10'd2}));

        // R10: reset wins over a simultaneous issue
        drive(1'b1, 4'd0, 10'd5, {L{32'd1}}, {L{32'd1}});
        rst_n = 0;
        @(negedge clk);
        rst_n = 1; idle();
        chk("R10 reset with issue", BW'({wr_en, wr_base}), '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule